// File: doc/BRIEF.md
# Power-Good Output Sequencer

This block drives a pair of matching power-good outputs for a board. It watches a supply rail through two digital threshold flags: one says the rail is above its rising threshold and one says it is below its falling threshold. It also watches a power-good signal from an external supply and a front-panel reset button. When the rail first climbs past its rising threshold, a hold-off counter starts. Both outputs go high once three things are true: the hold-off count has run out, the external supply reports good, and a front-panel settle delay has elapsed since the button was released.

The outputs drop as soon as a synchronized input reports a fault. A fault is the rail falling below its lower threshold, the external good going away, or the front-panel reset being pressed. The two thresholds form a hysteresis band. While the rail sits between them, nothing changes. If the rail dips below the lower threshold, even briefly, the hold-off interval starts over from zero. The front-panel delay is set in milliseconds and converted to clock cycles from a clock-frequency parameter. The millisecond value is kept inside a 28 to 39 ms window.

Top module: `pgs_power_good_seq`

## Requirements
- R1: While `rst` is high, both outputs are low and both delay counters are cleared. The outputs stay low on the first clock after reset is released.
- R2: The hold-off interval of HOLD_CYC cycles starts when `rail_above_hi` rises. It does not depend on `ext_good`. If the other conditions are already met, the outputs rise exactly HOLD_CYC+3 rising clock edges after `rail_above_hi` rises, and are still low after HOLD_CYC+2.
- R3: Suppose `ext_good` is still low when the hold-off interval ends. The outputs then stay low and rise 2 clock edges after `ext_good` rises, giving the hold-off time plus the extra wait.
- R4: If `ext_good` rises at any point during the hold-off interval, the outputs rise at the end of that interval, with the same timing as R2.
- R5: Both outputs fall 2 clock edges after `rail_below_lo` goes high or `ext_good` goes low. They are still high after 1 edge.
- R6: Suppose `rail_above_hi` falls while `rail_below_lo` stays low (rail inside the hysteresis band). The outputs stay high and the hold-off count is not restarted.
- R7: A `rail_below_lo` pulse as short as one clock restarts the full hold-off interval. With `rail_above_hi` high, the outputs rise again HOLD_CYC+3 edges after `rail_below_lo` returns low.
- R8: `panel_rst_n` is active low.
  - Pressing it drops the outputs 2 edges later.
  - After release, the outputs may rise no earlier than FP_CYC+2 edges, where FP_CYC = (CLK_HZ/1000) × FP_MS.
  - FP_MS is clamped to the range 28 to 39.
- R9: `pg_main` and `pg_aux` carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_above_hi | input | 1 | Rail is above its rising threshold (asynchronous) |
| rail_below_lo | input | 1 | Rail is below its falling threshold (asynchronous) |
| ext_good | input | 1 | External supply power-good, active high (asynchronous) |
| panel_rst_n | input | 1 | Front-panel reset, active low (asynchronous) |
| pg_main | output | 1 | Primary power-good output |
| pg_aux | output | 1 | Secondary power-good output, same as `pg_main` |

## Verification
Every input passes through a two-stage synchronizer. A fault therefore shows at the outputs on the second rising edge after it is applied. An `ext_good` arrival after the hold-off has run out also shows on the second edge. A rail rise or glitch recovery adds one edge for the hysteresis register plus HOLD_CYC edges of counting, so it lands on edge HOLD_CYC+3. A panel release lands on edge FP_CYC+2. The bench drives inputs on falling edges and counts rising edges from there. It samples on the falling edge right after the edge where a change is due, and also one edge earlier. This pins each result to its exact cycle rather than to a window.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  localparam int unsigned PANEL_MS_LO = 28;
  localparam int unsigned PANEL_MS_HI = 39;

  // Synchronized input bundle; field order fixes the bit layout of the sync chain.
  typedef struct packed {
    logic panel_n;
    logic ext;
    logic lo;
    logic hi;
  } in_bus_t;

  function automatic int unsigned clamp_ms(input int unsigned ms);
    if (ms < PANEL_MS_LO) return PANEL_MS_LO;
    if (ms > PANEL_MS_HI) return PANEL_MS_HI;
    return ms;
  endfunction

  function automatic int unsigned ms_to_cycles(input int unsigned hz, input int unsigned ms);
    return (hz / 1000) * clamp_ms(ms);
  endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pgs_rail_hyst.sv
module pgs_rail_hyst (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_s,
  output logic rail_ok
);

  // Falling threshold wins over rising threshold.
  always_ff @(posedge clk) begin
    if (rst)       rail_ok <= 1'b0;
    else if (lo_s) rail_ok <= 1'b0;
    else if (hi_s) rail_ok <= 1'b1;
  end

  // R6: inside the band the state holds.
  assert_band_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!hi_s && !lo_s) |=> $stable(rail_ok));

  // R7: a low-threshold report always clears the rail state.
  assert_low_clears_R7: assert property (@(posedge clk) disable iff (rst)
    lo_s |=> !rail_ok);

endmodule

// File: rtl/pgs_delay_cnt.sv
module pgs_delay_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  // R1/R2: the counter never runs past its limit.
  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  // R7: a clear always restarts the count from zero.
  assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> !done);

  // R6: expiry is sticky until cleared.
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done);

endmodule

// File: rtl/pgs_power_good_seq.sv
module pgs_power_good_seq
  import pgs_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 25_000_000,
  parameter int unsigned FP_MS       = 32,
  parameter int unsigned HOLD_CYC    = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_above_hi,
  input  logic rail_below_lo,
  input  logic ext_good,
  input  logic panel_rst_n,
  output logic pg_main,
  output logic pg_aux
);

  localparam int unsigned FP_CYC = ms_to_cycles(CLK_HZ, FP_MS);
  localparam int          BUS_W  = $bits(in_bus_t);

  in_bus_t raw, syn;
  logic    rail_ok, hold_done, fp_done, panel_act_s, hold_clr, pg_w;

  assign raw.panel_n = panel_rst_n;
  assign raw.ext     = ext_good;
  assign raw.lo      = rail_below_lo;
  assign raw.hi      = rail_above_hi;

  pgs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  pgs_rail_hyst u_hyst (
    .clk     (clk),
    .rst     (rst),
    .hi_s    (syn.hi),
    .lo_s    (syn.lo),
    .rail_ok (rail_ok)
  );

  assign hold_clr    = ~rail_ok | syn.lo;
  assign panel_act_s = ~syn.panel_n;

  pgs_delay_cnt #(.LIMIT(HOLD_CYC)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .clr  (hold_clr),
    .done (hold_done)
  );

  pgs_delay_cnt #(.LIMIT(FP_CYC)) u_panel (
    .clk  (clk),
    .rst  (rst),
    .clr  (panel_act_s),
    .done (fp_done)
  );

  // Qualify with synchronized fault inputs so loss of good bypasses counter latency.
  assign pg_w    = hold_done & fp_done & syn.ext & ~syn.lo & ~panel_act_s;
  assign pg_main = pg_w;
  assign pg_aux  = pg_w;

  // R2: a rise is only possible after the rail state was established.
  assert_rise_after_rail_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_main) |-> $past(rail_ok));

  // R8: a rise is only possible with the panel released for at least a cycle.
  assert_rise_after_panel_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_main) |-> $past(!panel_act_s));

  // R5: a synchronized rail fault is followed by low outputs.
  assert_low_fault_drops_R5: assert property (@(posedge clk) disable iff (rst)
    syn.lo |=> !pg_main);

endmodule

// File: tb/sim_pgs_power_good_seq.sv
module sim_pgs_power_good_seq;

  localparam int unsigned HZ = 100_000;
  localparam int unsigned MS = 32;
  localparam int          H  = 20;
  localparam int          F  = (HZ / 1000) * MS;

  logic clk = 1'b0;
  logic rst, rail_above_hi, rail_below_lo, ext_good, panel_rst_n;
  logic pg_main, pg_aux;
  int   total = 0;
  int   bad   = 0;

  always #5 clk = ~clk;

  pgs_power_good_seq #(.CLK_HZ(HZ), .FP_MS(MS), .HOLD_CYC(H), .SYNC_STAGES(2)) u0 (
    .clk           (clk),
    .rst           (rst),
    .rail_above_hi (rail_above_hi),
    .rail_below_lo (rail_below_lo),
    .ext_good      (ext_good),
    .panel_rst_n   (panel_rst_n),
    .pg_main       (pg_main),
    .pg_aux        (pg_aux)
  );

  // Every check also compares both outputs (R9).
  task automatic chk(input logic exp, input string req);
    total++;
    if (pg_main !== exp || pg_aux !== exp) begin
      bad++;
      $display("FAIL %s/R9: pg_main=%b pg_aux=%b expected=%b", req, pg_main, pg_aux, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; rail_above_hi = 1'b0; rail_below_lo = 1'b1;
    ext_good = 1'b0; panel_rst_n = 1'b0;
    edges(4);
    chk(1'b0, "R1 in reset");
    rst = 1'b0;
    edges(1);
    chk(1'b0, "R1 after release");
  endtask

  task automatic t_panel;
    panel_rst_n = 1'b1; rail_below_lo = 1'b0; rail_above_hi = 1'b1; ext_good = 1'b1;
    edges(F + 1);
    chk(1'b0, "R8 before panel delay");
    edges(1);
    chk(1'b1, "R8 at panel delay");
    panel_rst_n = 1'b0;
    edges(1);
    chk(1'b1, "R8 press edge1");
    edges(1);
    chk(1'b0, "R8 press edge2");
    panel_rst_n = 1'b1;
    edges(F + 1);
    chk(1'b0, "R8 second release early");
    edges(1);
    chk(1'b1, "R8 second release due");
  endtask

  task automatic t_ext_early;
    rail_above_hi = 1'b0; rail_below_lo = 1'b1;
    edges(1);
    chk(1'b1, "R5 rail low edge1");
    edges(1);
    chk(1'b0, "R5 rail low edge2");
    ext_good = 1'b0;
    edges(3);
    rail_below_lo = 1'b0; rail_above_hi = 1'b1;
    edges(5);
    ext_good = 1'b1;
    edges(H + 2 - 5);
    chk(1'b0, "R2 before hold-off end");
    edges(1);
    chk(1'b1, "R4 at hold-off end");
  endtask

  task automatic t_ext_late;
    ext_good = 1'b0;
    edges(1);
    chk(1'b1, "R5 ext loss edge1");
    edges(1);
    chk(1'b0, "R5 ext loss edge2");
    rail_below_lo = 1'b1; rail_above_hi = 1'b0;
    edges(4);
    rail_below_lo = 1'b0; rail_above_hi = 1'b1;
    edges(H + 10);
    chk(1'b0, "R3 waiting on ext");
    ext_good = 1'b1;
    edges(1);
    chk(1'b0, "R3 ext edge1");
    edges(1);
    chk(1'b1, "R3 ext edge2");
  endtask

  task automatic t_hyst;
    rail_above_hi = 1'b0;
    edges(10);
    chk(1'b1, "R6 inside band");
    rail_above_hi = 1'b1;
    edges(3);
    chk(1'b1, "R6 no restart");
  endtask

  task automatic t_glitch;
    rail_below_lo = 1'b1;
    edges(1);
    chk(1'b1, "R7 pulse edge1");
    rail_below_lo = 1'b0;
    edges(1);
    chk(1'b0, "R7 pulse seen");
    edges(H + 1);
    chk(1'b0, "R7 restart not done");
    edges(1);
    chk(1'b1, "R7 restart done");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_panel();
    t_ext_early();
    t_ext_late();
    t_hyst();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule